// File: doc/BRIEF.md
# Aliased Flag and Modulus Special-Register File

This block holds the special registers of a wide-arithmetic coprocessor. It has two flag groups of four bits each, a modulus of WLEN bits (256 by default), and an accumulator of the same width. It also passes through a random-number bus that comes from outside. Two access ports reach this state. The narrow port serves 32-bit control-register accesses. The wide port serves full-width special-register accesses. Each port supports two operations: read-and-write, and read-and-set-bits. In both operations the old value is returned combinationally in the cycle of the access, and the new value is committed at the next rising clock edge.

Some storage has more than one address. The flag bits can be reached through a group-0 view, a group-1 view and a combined view. The modulus can be written whole through the wide port, or one 32-bit slice at a time through a run of consecutive narrow addresses. The datapath can also reload either flag group directly through a per-group update strobe. An access to an address that is not decoded raises `illegal_o` and leaves all state unchanged.

Top module: `sreg_alias_file`

## Requirements
- R1: After reset, the flags, the modulus and the accumulator are all zero. A narrow read of the combined flag view returns 0.
- R2: Narrow address 0x7C0 is flag group 0 and 0x7C1 is flag group 1. In each of these views, bit 0 is carry, bit 1 is MSb, bit 2 is LSb and bit 3 is zero. Bits 31:4 read as 0 and ignore writes. `flags_o[3:0]` is group 0 and `flags_o[7:4]` is group 1, with the same bit order.
- R3: Narrow address 0x7C8 is the combined view, with group 0 in bits 3:0 and group 1 in bits 7:4. Bits 31:8 read as 0 and ignore writes.
- R4: Operation code 1 (read-and-set) returns the old value and stores the old value OR the operand. Operation code 0 (read-and-write) returns the old value and stores the operand.
- R5: Narrow addresses 0x7D0+k, for k from 0 to 7, read and write modulus bits [32k+31:32k].
- R6: Wide address 0x0 reads and writes the whole modulus. It shows any slice written earlier through the narrow port, and the reverse also holds.
- R7: Wide address 0x2 reads and writes the accumulator, with both operation codes.
- R8: Narrow address 0xFC0 returns `rnd_i[31:0]` and wide address 0x1 returns `rnd_i`. Writes to either address are legal, do not raise `illegal_o`, and change no state.
- R9: An access to any other address raises `illegal_o` in the same cycle, reads as 0 and changes no state.
- R10: `flag_upd_i[g]` loads group g from `flag_upd_data_i[4g+3:4g]` at the next edge. If a narrow write targets the same group in the same cycle, the narrow write wins. A group that is not targeted still takes its update.
- R11: If the wide port and the narrow port write the modulus in the same cycle, the wide write wins over the whole width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_en_i | input | 1 | Narrow access strobe |
| csr_op_i | input | 1 | Narrow operation: 0 read-and-write, 1 read-and-set |
| csr_addr_i | input | 12 | Narrow address |
| csr_wdata_i | input | XLEN | Narrow operand |
| csr_rdata_o | output | XLEN | Narrow old value |
| wsr_en_i | input | 1 | Wide access strobe |
| wsr_op_i | input | 1 | Wide operation: 0 read-and-write, 1 read-and-set |
| wsr_addr_i | input | WSR_AW | Wide address |
| wsr_wdata_i | input | WLEN | Wide operand |
| wsr_rdata_o | output | WLEN | Wide old value |
| flag_upd_i | input | 2 | Per-group datapath flag update strobes |
| flag_upd_data_i | input | 8 | Datapath flag values, group g in bits 4g+3:4g |
| rnd_i | input | WLEN | Random value from an external source |
| illegal_o | output | 1 | Access to an undecoded address |
| flags_o | output | 8 | Current flag groups |
| mod_o | output | WLEN | Current modulus |
| acc_o | output | WLEN | Current accumulator |

## Verification
Because all three aliased views read the same storage, a wrong flag bit shows in `flags_o` and in every view on the cycle after the write that caused it. A write to the wrong modulus slice shows in `mod_o` and in the wide read-back one cycle later. A wrong priority between a datapath update and a narrow write leaves a stale group on `flags_o` right after the shared edge. A decode slip shows in the same cycle, either as `illegal_o` asserted on a valid address or as non-zero read data on an undecoded one.

// File: rtl/sreg_alias_pkg.sv
package sreg_alias_pkg;
   localparam int unsigned NGRP = 2;
   localparam int unsigned GRPW = 4;

   typedef enum logic {
      OP_WRITE = 1'b0,
      OP_SET   = 1'b1
   } sr_op_e;

   typedef enum logic [2:0] {
      NT_NONE,
      NT_GRP0,
      NT_GRP1,
      NT_BOTH,
      NT_MODSL,
      NT_RAND
   } narrow_tgt_e;

   typedef enum logic [1:0] {
      WT_NONE,
      WT_MOD,
      WT_RAND,
      WT_ACC
   } wide_tgt_e;

   localparam logic [11:0] A_GRP0  = 12'h7C0;
   localparam logic [11:0] A_GRP1  = 12'h7C1;
   localparam logic [11:0] A_BOTH  = 12'h7C8;
   localparam logic [11:0] A_MOD0  = 12'h7D0;
   localparam logic [11:0] A_RAND  = 12'hFC0;
   localparam int unsigned W_MOD  = 0;
   localparam int unsigned W_RAND = 1;
   localparam int unsigned W_ACC  = 2;
endpackage

// File: rtl/sreg_addr_decode.sv
module sreg_addr_decode
   import sreg_alias_pkg::*;
#(
   parameter int unsigned NSLICE = 8,
   parameter int unsigned WSR_AW = 8,
   localparam int unsigned SIW   = (NSLICE > 1) ? $clog2(NSLICE) : 1
) (
   input  logic [11:0]       n_addr_i,
   input  logic [WSR_AW-1:0] w_addr_i,
   output narrow_tgt_e       n_tgt_o,
   output logic [SIW-1:0]    n_slice_o,
   output wide_tgt_e         w_tgt_o
);
   logic [11:0] off;

   assign off       = n_addr_i - A_MOD0;
   assign n_slice_o = off[SIW-1:0];

   always_comb begin
      n_tgt_o = NT_NONE;
      if (n_addr_i == A_GRP0)                      n_tgt_o = NT_GRP0;
      else if (n_addr_i == A_GRP1)                 n_tgt_o = NT_GRP1;
      else if (n_addr_i == A_BOTH)                 n_tgt_o = NT_BOTH;
      else if (n_addr_i == A_RAND)                 n_tgt_o = NT_RAND;
      else if (n_addr_i >= A_MOD0 &&
               off < 12'(NSLICE))                  n_tgt_o = NT_MODSL;
   end

   always_comb begin
      w_tgt_o = WT_NONE;
      if (w_addr_i == WSR_AW'(W_MOD))       w_tgt_o = WT_MOD;
      else if (w_addr_i == WSR_AW'(W_RAND)) w_tgt_o = WT_RAND;
      else if (w_addr_i == WSR_AW'(W_ACC))  w_tgt_o = WT_ACC;
   end
endmodule

// File: rtl/sreg_flag_bank.sv
module sreg_flag_bank
   import sreg_alias_pkg::*;
#(
   parameter int unsigned NG = NGRP,
   parameter int unsigned GW = GRPW
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic [NG-1:0]    upd_en_i,
   input  logic [NG*GW-1:0] upd_data_i,
   input  logic [NG-1:0]    sw_we_i,
   input  logic [NG*GW-1:0] sw_data_i,
   output logic [NG*GW-1:0] flags_o
);
   for (genvar g = 0; g < NG; g++) begin : g_grp
      logic [GW-1:0] grp_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)             grp_q <= '0;
         else if (sw_we_i[g])     grp_q <= sw_data_i[g*GW +: GW];
         else if (upd_en_i[g])    grp_q <= upd_data_i[g*GW +: GW];
      end

      assign flags_o[g*GW +: GW] = grp_q;

      // R10: software write has priority over datapath update
      assert_sw_beats_upd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (sw_we_i[g] && upd_en_i[g]) |=> grp_q == $past(sw_data_i[g*GW +: GW]));
      assert_upd_loads_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!sw_we_i[g] && upd_en_i[g]) |=> grp_q == $past(upd_data_i[g*GW +: GW]));
   end
endmodule

// File: rtl/sreg_slice_reg.sv
module sreg_slice_reg #(
   parameter int unsigned WLEN = 256,
   parameter int unsigned XLEN = 32,
   parameter bit          HAS_SLICES = 1'b1,
   localparam int unsigned NS  = WLEN / XLEN,
   localparam int unsigned SIW = (NS > 1) ? $clog2(NS) : 1
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            wide_we_i,
   input  logic [WLEN-1:0] wide_data_i,
   input  logic            sl_we_i,
   input  logic [SIW-1:0]  sl_idx_i,
   input  logic [XLEN-1:0] sl_data_i,
   output logic [WLEN-1:0] q_o
);
   if (HAS_SLICES) begin : g_sliced
      for (genvar s = 0; s < NS; s++) begin : g_sl
         logic [XLEN-1:0] sq;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                                  sq <= '0;
            else if (wide_we_i)                           sq <= wide_data_i[s*XLEN +: XLEN];
            else if (sl_we_i && sl_idx_i == SIW'(s))      sq <= sl_data_i;
         end
         assign q_o[s*XLEN +: XLEN] = sq;
      end
   end else begin : g_whole
      logic [WLEN-1:0] wq;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)        wq <= '0;
         else if (wide_we_i) wq <= wide_data_i;
      end
      assign q_o = wq;
      logic unused_sl;
      assign unused_sl = sl_we_i ^ (^sl_idx_i) ^ (^sl_data_i);
   end

   // R11: a wide write overrides any concurrent slice write
   assert_wide_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wide_we_i |=> q_o == $past(wide_data_i));
endmodule

// File: rtl/sreg_alias_file.sv
module sreg_alias_file
   import sreg_alias_pkg::*;
#(
   parameter int unsigned XLEN   = 32,
   parameter int unsigned WLEN   = 256,
   parameter int unsigned WSR_AW = 8,
   localparam int unsigned NSL   = WLEN / XLEN,
   localparam int unsigned SIW   = (NSL > 1) ? $clog2(NSL) : 1,
   localparam int unsigned FW    = NGRP * GRPW
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              csr_en_i,
   input  logic              csr_op_i,
   input  logic [11:0]       csr_addr_i,
   input  logic [XLEN-1:0]   csr_wdata_i,
   output logic [XLEN-1:0]   csr_rdata_o,
   input  logic              wsr_en_i,
   input  logic              wsr_op_i,
   input  logic [WSR_AW-1:0] wsr_addr_i,
   input  logic [WLEN-1:0]   wsr_wdata_i,
   output logic [WLEN-1:0]   wsr_rdata_o,
   input  logic [NGRP-1:0]   flag_upd_i,
   input  logic [FW-1:0]     flag_upd_data_i,
   input  logic [WLEN-1:0]   rnd_i,
   output logic              illegal_o,
   output logic [FW-1:0]     flags_o,
   output logic [WLEN-1:0]   mod_o,
   output logic [WLEN-1:0]   acc_o
);
   if (NSL * XLEN != WLEN) begin : g_bad_ratio
      $error("WLEN must be a whole multiple of XLEN");
   end
   if (NSL > 16) begin : g_bad_slices
      $error("modulus slice window holds at most 16 addresses");
   end
   if (XLEN < FW) begin : g_bad_xlen
      $error("XLEN too narrow for the combined flag view");
   end

   narrow_tgt_e    n_tgt;
   wide_tgt_e      w_tgt;
   logic [SIW-1:0] n_slice;

   sreg_addr_decode #(.NSLICE(NSL), .WSR_AW(WSR_AW)) u_dec (
      .n_addr_i (csr_addr_i),
      .w_addr_i (wsr_addr_i),
      .n_tgt_o  (n_tgt),
      .n_slice_o(n_slice),
      .w_tgt_o  (w_tgt)
   );

   logic [XLEN-1:0] n_old, n_new;
   logic [WLEN-1:0] w_old, w_new;

   always_comb begin
      n_old = '0;
      unique case (n_tgt)
         NT_GRP0:  n_old = XLEN'(flags_o[GRPW-1:0]);
         NT_GRP1:  n_old = XLEN'(flags_o[2*GRPW-1:GRPW]);
         NT_BOTH:  n_old = XLEN'(flags_o);
         NT_MODSL: n_old = mod_o[n_slice*XLEN +: XLEN];
         NT_RAND:  n_old = rnd_i[XLEN-1:0];
         default:  n_old = '0;
      endcase
   end

   assign n_new       = (sr_op_e'(csr_op_i) == OP_SET) ? (n_old | csr_wdata_i) : csr_wdata_i;
   assign csr_rdata_o = csr_en_i ? n_old : '0;

   always_comb begin
      w_old = '0;
      unique case (w_tgt)
         WT_MOD:  w_old = mod_o;
         WT_RAND: w_old = rnd_i;
         WT_ACC:  w_old = acc_o;
         default: w_old = '0;
      endcase
   end

   assign w_new       = (sr_op_e'(wsr_op_i) == OP_SET) ? (w_old | wsr_wdata_i) : wsr_wdata_i;
   assign wsr_rdata_o = wsr_en_i ? w_old : '0;

   assign illegal_o = (csr_en_i && n_tgt == NT_NONE) || (wsr_en_i && w_tgt == WT_NONE);

   // flag write steering for the three aliased views
   logic [NGRP-1:0] fl_we;
   logic [FW-1:0]   fl_wd;

   always_comb begin
      fl_we = '0;
      fl_wd = '0;
      if (csr_en_i) begin
         unique case (n_tgt)
            NT_GRP0: begin fl_we = 2'b01; fl_wd = {{GRPW{1'b0}}, n_new[GRPW-1:0]}; end
            NT_GRP1: begin fl_we = 2'b10; fl_wd = {n_new[GRPW-1:0], {GRPW{1'b0}}}; end
            NT_BOTH: begin fl_we = 2'b11; fl_wd = n_new[FW-1:0]; end
            default: ;
         endcase
      end
   end

   sreg_flag_bank #(.NG(NGRP), .GW(GRPW)) u_flags (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .upd_en_i  (flag_upd_i),
      .upd_data_i(flag_upd_data_i),
      .sw_we_i   (fl_we),
      .sw_data_i (fl_wd),
      .flags_o   (flags_o)
   );

   logic mod_wide_we, mod_sl_we, acc_we;
   assign mod_wide_we = wsr_en_i && w_tgt == WT_MOD;
   assign acc_we      = wsr_en_i && w_tgt == WT_ACC;
   assign mod_sl_we   = csr_en_i && n_tgt == NT_MODSL;

   sreg_slice_reg #(.WLEN(WLEN), .XLEN(XLEN), .HAS_SLICES(1'b1)) u_mod (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wide_we_i  (mod_wide_we),
      .wide_data_i(w_new),
      .sl_we_i    (mod_sl_we),
      .sl_idx_i   (n_slice),
      .sl_data_i  (n_new),
      .q_o        (mod_o)
   );

   sreg_slice_reg #(.WLEN(WLEN), .XLEN(XLEN), .HAS_SLICES(1'b0)) u_acc (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wide_we_i  (acc_we),
      .wide_data_i(w_new),
      .sl_we_i    (1'b0),
      .sl_idx_i   ('0),
      .sl_data_i  ('0),
      .q_o        (acc_o)
   );

   // R9: an undecoded access alone leaves every register untouched
   assert_illegal_no_change_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (illegal_o && !(csr_en_i && n_tgt != NT_NONE) && !(wsr_en_i && w_tgt != WT_NONE)
       && flag_upd_i == '0)
      |=> ($stable(flags_o) && $stable(mod_o) && $stable(acc_o)));
   assert_illegal_reads_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (csr_en_i && n_tgt == NT_NONE) |-> csr_rdata_o == '0);
   // R8: writes to the random source alter nothing
   assert_rand_write_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (csr_en_i && n_tgt == NT_RAND && !wsr_en_i && flag_upd_i == '0)
      |=> ($stable(flags_o) && $stable(mod_o) && $stable(acc_o)));
   // R4: read-and-set on the combined view ORs into the flags
   assert_flag_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (csr_en_i && csr_op_i && n_tgt == NT_BOTH)
      |=> flags_o == ($past(flags_o) | $past(csr_wdata_i[FW-1:0])));
   // R6: a slice write lands in the matching part of the modulus
   assert_slice_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mod_sl_we && !mod_wide_we && !csr_op_i)
      |=> mod_o[$past(n_slice)*XLEN +: XLEN] == $past(csr_wdata_i));
endmodule

// File: tb/sreg_alias_file_test.sv
module sreg_alias_file_test;
   localparam int XLEN = 32;
   localparam int WLEN = 256;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            csr_en = 1'b0, csr_op = 1'b0;
   logic [11:0]     csr_addr = '0;
   logic [XLEN-1:0] csr_wdata = '0, csr_rdata;
   logic            wsr_en = 1'b0, wsr_op = 1'b0;
   logic [7:0]      wsr_addr = '0;
   logic [WLEN-1:0] wsr_wdata = '0, wsr_rdata;
   logic [1:0]      upd = '0;
   logic [7:0]      upd_data = '0;
   logic [WLEN-1:0] rnd = '0;
   logic            illegal;
   logic [7:0]      flags;
   logic [WLEN-1:0] mod_v, acc_v;

   int n_chk = 0, n_err = 0;
   bit done = 0;

   logic [7:0]      e_flags = '0;
   logic [WLEN-1:0] e_mod = '0, e_acc = '0;

   always #5 clk = ~clk;

   sreg_alias_file uut (
      .clk_i(clk), .rst_ni(rst_n),
      .csr_en_i(csr_en), .csr_op_i(csr_op), .csr_addr_i(csr_addr),
      .csr_wdata_i(csr_wdata), .csr_rdata_o(csr_rdata),
      .wsr_en_i(wsr_en), .wsr_op_i(wsr_op), .wsr_addr_i(wsr_addr),
      .wsr_wdata_i(wsr_wdata), .wsr_rdata_o(wsr_rdata),
      .flag_upd_i(upd), .flag_upd_data_i(upd_data), .rnd_i(rnd),
      .illegal_o(illegal), .flags_o(flags), .mod_o(mod_v), .acc_o(acc_v)
   );

   task automatic chk(input string req, input logic [WLEN-1:0] act, input logic [WLEN-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic chk_state(input string req);
      chk({req, " flags"}, WLEN'(flags), WLEN'(e_flags));
      chk({req, " mod"}, mod_v, e_mod);
      chk({req, " acc"}, acc_v, e_acc);
   endtask

   task automatic n_acc(input logic op, input logic [11:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic ill);
      @(negedge clk);
      csr_en = 1'b1; csr_op = op; csr_addr = a; csr_wdata = d;
      #1;
      rd = csr_rdata; ill = illegal;
      @(negedge clk);
      csr_en = 1'b0;
   endtask

   task automatic w_acc(input logic op, input logic [7:0] a, input logic [WLEN-1:0] d,
                        output logic [WLEN-1:0] rd, output logic ill);
      @(negedge clk);
      wsr_en = 1'b1; wsr_op = op; wsr_addr = a; wsr_wdata = d;
      #1;
      rd = wsr_rdata; ill = illegal;
      @(negedge clk);
      wsr_en = 1'b0;
   endtask

   task automatic t_reset;
      logic [31:0] rd; logic ill;
      chk_state("R1 reset");
      n_acc(1'b1, 12'h7C8, 32'h0, rd, ill);
      chk("R1 flags view after reset", WLEN'(rd), '0);
      chk_state("R1 zero set keeps state");
   endtask

   task automatic t_group_views;
      logic [31:0] rd; logic ill;
      n_acc(1'b0, 12'h7C1, 32'hFFFF_FFFA, rd, ill);
      e_flags[7:4] = 4'hA;
      chk_state("R2 group1 write");
      n_acc(1'b0, 12'h7C0, 32'h0, rd, ill);
      chk("R2 group0 read", WLEN'(rd), '0);
      n_acc(1'b0, 12'h7C8, 32'h0000_00A0, rd, ill);
      chk("R2 combined shows group1", WLEN'(rd), WLEN'(32'hA0));
      n_acc(1'b0, 12'h7C0, 32'h0000_0005, rd, ill);
      e_flags[3:0] = 4'h5;
      chk_state("R2 group0 carry+LSb");
   endtask

   task automatic t_combined;
      logic [31:0] rd; logic ill;
      n_acc(1'b0, 12'h7C8, 32'hFFFF_FF5C, rd, ill);
      chk("R3 combined returns old", WLEN'(rd), WLEN'(32'hA5));
      e_flags = 8'h5C;
      chk_state("R3 combined write");
      n_acc(1'b0, 12'h7C8, 32'h0000_005C, rd, ill);
      chk("R3 upper bits read 0", WLEN'(rd), WLEN'(32'h5C));
      n_acc(1'b0, 12'h7C1, 32'h5, rd, ill);
      chk("R3 group1 view", WLEN'(rd), WLEN'(32'h5));
   endtask

   task automatic t_set;
      logic [31:0] rd; logic ill;
      n_acc(1'b1, 12'h7C0, 32'h0000_0003, rd, ill);
      chk("R4 set returns old", WLEN'(rd), WLEN'(32'hC));
      e_flags[3:0] = 4'hF;
      chk_state("R4 set ORs");
      n_acc(1'b1, 12'h7C8, 32'hFFFF_FF80, rd, ill);
      chk("R4 combined set returns old", WLEN'(rd), WLEN'(32'h5F));
      e_flags = 8'hDF;
      chk_state("R4 combined set");
   endtask

   task automatic t_slices;
      logic [31:0] rd; logic ill; logic [WLEN-1:0] wrd;
      for (int k = 0; k < 8; k++) begin
         n_acc(1'b0, 12'h7D0 + 12'(k), 32'hC0DE_0000 | 32'(k * 17), rd, ill);
         e_mod[k*32 +: 32] = 32'hC0DE_0000 | 32'(k * 17);
         chk("R5 slice legal", WLEN'(ill), '0);
      end
      chk_state("R5 slices assembled");
      n_acc(1'b1, 12'h7D5, 32'h0100_0000, rd, ill);
      chk("R5 slice5 old", WLEN'(rd), WLEN'(32'hC0DE_0055));
      e_mod[5*32 +: 32] = 32'hC1DE_0055;
      chk_state("R5 slice set");
      w_acc(1'b0, 8'h0, {8{32'h1234_5678}}, wrd, ill);
      chk("R6 wide read of slices", wrd, e_mod);
      e_mod = {8{32'h1234_5678}};
      chk_state("R6 wide write");
      n_acc(1'b0, 12'h7D3, 32'h0, rd, ill);
      chk("R6 slice view of wide", WLEN'(rd), WLEN'(32'h1234_5678));
      e_mod[3*32 +: 32] = '0;
   endtask

   task automatic t_acc;
      logic [WLEN-1:0] wrd; logic ill;
      w_acc(1'b0, 8'h2, {64{4'h3}}, wrd, ill);
      chk("R7 acc old", wrd, '0);
      e_acc = {64{4'h3}};
      chk_state("R7 acc write");
      w_acc(1'b1, 8'h2, {64{4'h8}}, wrd, ill);
      chk("R7 acc set old", wrd, {64{4'h3}});
      e_acc = {64{4'hB}};
      chk_state("R7 acc set");
   endtask

   task automatic t_rand;
      logic [31:0] rd; logic ill; logic [WLEN-1:0] wrd;
      rnd = {8{32'h9E37_79B9}} ^ {WLEN{1'b1}} >> 3;
      n_acc(1'b0, 12'hFC0, 32'hFFFF_FFFF, rd, ill);
      chk("R8 narrow rand", WLEN'(rd), WLEN'(rnd[31:0]));
      chk("R8 narrow rand legal", WLEN'(ill), '0);
      chk_state("R8 narrow rand write ignored");
      w_acc(1'b1, 8'h1, {WLEN{1'b1}}, wrd, ill);
      chk("R8 wide rand", wrd, rnd);
      chk("R8 wide rand legal", WLEN'(ill), '0);
      chk_state("R8 wide rand write ignored");
   endtask

   task automatic t_illegal;
      logic [31:0] rd; logic ill; logic [WLEN-1:0] wrd;
      n_acc(1'b0, 12'h7C2, 32'hFFFF_FFFF, rd, ill);
      chk("R9 7C2 illegal", WLEN'(ill), WLEN'(1));
      chk("R9 7C2 reads 0", WLEN'(rd), '0);
      n_acc(1'b0, 12'h7D8, 32'hFFFF_FFFF, rd, ill);
      chk("R9 7D8 illegal", WLEN'(ill), WLEN'(1));
      w_acc(1'b0, 8'h3, {WLEN{1'b1}}, wrd, ill);
      chk("R9 wide 3 illegal", WLEN'(ill), WLEN'(1));
      chk("R9 wide 3 reads 0", wrd, '0);
      chk_state("R9 no state change");
   endtask

   task automatic t_update;
      logic [31:0] rd; logic ill;
      @(negedge clk);
      upd = 2'b10; upd_data = 8'h70;
      @(negedge clk);
      upd = 2'b00;
      e_flags[7:4] = 4'h7;
      chk_state("R10 group1 update only");
      @(negedge clk);
      upd = 2'b11; upd_data = 8'h96;
      csr_en = 1'b1; csr_op = 1'b0; csr_addr = 12'h7C0; csr_wdata = 32'h1;
      @(negedge clk);
      upd = 2'b00; csr_en = 1'b0;
      e_flags = 8'h91;
      chk_state("R10 narrow write beats update");
      n_acc(1'b0, 12'h7C8, 32'h91, rd, ill);
      chk("R10 combined view", WLEN'(rd), WLEN'(32'h91));
   endtask

   task automatic t_collide;
      @(negedge clk);
      wsr_en = 1'b1; wsr_op = 1'b0; wsr_addr = 8'h0; wsr_wdata = {32{8'h55}};
      csr_en = 1'b1; csr_op = 1'b0; csr_addr = 12'h7D2; csr_wdata = 32'hDEAD_BEEF;
      @(negedge clk);
      wsr_en = 1'b0; csr_en = 1'b0;
      e_mod = {32{8'h55}};
      chk_state("R11 wide beats slice");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_group_views();
      t_combined();
      t_set();
      t_slices();
      t_acc();
      t_rand();
      t_illegal();
      t_update();
      t_collide();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog act=hung exp=done");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end
endmodule